// File: doc/BRIEF.md
# Direct/Duplex LCD Waveform Sequencer

This block produces the drive codes for a small segment display: thirty-two segment outputs and two backplane outputs, each given as a 2-bit level code (low, mid, high, or released). Its inputs are eight 8-bit segment registers, a mode bit choosing two-level static drive or three-level duplex drive, and a bank bit. The bank bit chooses which half of the registers is shown in two-level drive. A phase counter steps on each tick from a local oscillator divider. The segment levels are then chosen against the backplane that is active in the current phase. An "on" segment is driven to the opposite level and an "off" segment to the same level.

When several devices share one set of backplanes, a follower device runs in cascade mode. It takes its phase from the backplane levels it observes and releases its own backplane pins. A further expander mode drives each segment straight from its register bit with no oscillator, so the block can also serve as a 32-bit output port. After reset, and until the first phase event, the block holds a blank display.

Top module: `lcdWaveSeq`

## Requirements
- R1: Level codes are LOW=2'b00, MID=2'b01, HIGH=2'b10, OFF=2'b11. Register r occupies segRegs[8r+7:8r]. Segment n (0-based) occupies segLevels[2n+1:2n] and is fed by bit n%8 of register 2*(n/8) or 2*(n/8)+1. No segment is ever driven OFF.
- R2: In master two-level mode, the first tick after reset starts phase 0 and each later tick toggles the phase. bp1Level is HIGH in the even phase and LOW in the odd phase, and bp2Level is OFF. A tick sampled at clock edge N shows on the outputs after edge N+1.
- R3: In two-level mode, a segment whose bit is 1 takes the opposite level of bp1, and a segment whose bit is 0 takes the same level.
- R4: In two-level mode, bankSel=0 shows the even registers and bankSel=1 shows the odd registers.
- R5: In duplex mode the phases run 0,1,2,3 and then repeat. The backplane pair (bp1,bp2) is (HIGH,MID), (LOW,MID), (MID,HIGH), (MID,LOW) in those phases, so whenever one backplane is at MID the other is HIGH or LOW.
- R6: In duplex mode, phases 0 and 1 use the even register bit and phases 2 and 3 use the odd one. A set bit drives the level opposite the active backplane and a clear bit drives the same level. bankSel has no effect.
- R7: In cascade mode both backplane outputs are OFF and oscTick is ignored. The phase is loaded from extBp1 (HIGH gives phase 0, LOW gives phase 1). In duplex mode only, it is also loaded from extBp2 (HIGH gives phase 2, LOW gives phase 3). Any other combination holds the phase.
- R8: With expanderMode=1, two-level mode and master operation, each segment is HIGH for a set bit and LOW for a clear bit of the bank-selected register. bp1Level is LOW and bp2Level is OFF, and no tick is needed.
- R9: During reset, and until the first tick (master) or the first valid external phase (cascade), all segments are LOW. Both backplanes are LOW in master mode and OFF in cascade mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| segRegs | input | 64 | Eight segment registers, register r at bits [8r+7:8r] |
| duplexMode | input | 1 | 0 = two-level drive, 1 = duplex drive |
| bankSel | input | 1 | Bank shown in two-level drive |
| cascadeMode | input | 1 | 1 = follower that syncs to external backplanes |
| expanderMode | input | 1 | 1 = static output-port drive (two-level, master only) |
| oscTick | input | 1 | Phase-step strobe from the local divider |
| extBp1 | input | 2 | Observed level code of backplane 1 |
| extBp2 | input | 2 | Observed level code of backplane 2 |
| segLevels | output | 64 | Segment level codes, segment n at bits [2n+1:2n] |
| bp1Level | output | 2 | Backplane 1 level code |
| bp2Level | output | 2 | Backplane 2 level code |

## Verification
The bench targets these corner cases:
- The gap between reset and the first tick. A design that skipped blanking would show a live waveform with nothing clocking it.
- Switching the bank with no tick. A swapped bank decode would show the wrong half of the registers.
- The duplex half-frame boundary. Choosing the register from the wrong phase bit would drive backplane-2 data against backplane 1 and break the single-MID pairing.
- Cascade sync from a released backplane level. A follower that kept driving its backplanes, or that decoded extBp2 in two-level mode, would contend with the master or jump phase.
- Expander mode. Blanking it until a tick would leave an output port stuck low.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_OFF  = 2'b11
  } lvl_e;

  // Control state handed to the datapath each cycle
  typedef struct packed {
    logic       live;      // first phase event seen since reset
    logic       staticOn;  // expander drive active
    logic       duplex;
    logic       cascade;
    logic       bankSel;
    logic [1:0] phase;
  } seqStrobe_t;

endpackage

// File: rtl/lcdSeqCtrl.sv
module lcdSeqCtrl
  import lcd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       duplexMode,
  input  logic       bankSel,
  input  logic       cascadeMode,
  input  logic       expanderMode,
  input  logic       oscTick,
  input  logic [1:0] extBp1,
  input  logic [1:0] extBp2,
  output seqStrobe_t strb
);

  logic [1:0] phaseQ;
  logic       liveQ;
  logic       extValid;
  logic [1:0] extPhase;

  // Recover the phase from the levels a master is putting on the backplanes
  always_comb begin
    extValid = 1'b0;
    extPhase = 2'd0;
    if (extBp1 == LVL_HIGH) begin
      extValid = 1'b1;
      extPhase = 2'd0;
    end else if (extBp1 == LVL_LOW) begin
      extValid = 1'b1;
      extPhase = 2'd1;
    end else if (duplexMode && extBp2 == LVL_HIGH) begin
      extValid = 1'b1;
      extPhase = 2'd2;
    end else if (duplexMode && extBp2 == LVL_LOW) begin
      extValid = 1'b1;
      extPhase = 2'd3;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 2'd0;
      liveQ  <= 1'b0;
    end else if (cascadeMode) begin
      if (extValid) begin
        phaseQ <= extPhase;
        liveQ  <= 1'b1;
      end
    end else if (oscTick) begin
      if (!liveQ) begin
        phaseQ <= 2'd0;
        liveQ  <= 1'b1;
      end else if (duplexMode) begin
        phaseQ <= phaseQ + 2'd1;
      end else begin
        phaseQ <= {1'b0, ~phaseQ[0]};
      end
    end
  end

  assign strb.live     = liveQ;
  assign strb.staticOn = expanderMode & ~duplexMode & ~cascadeMode;
  assign strb.duplex   = duplexMode;
  assign strb.cascade  = cascadeMode;
  assign strb.bankSel  = bankSel;
  assign strb.phase    = phaseQ;

endmodule

// File: rtl/lcdSegPath.sv
module lcdSegPath
  import lcd_seq_pkg::*;
#(
  parameter int SEG_COUNT = 32,
  parameter int REG_BITS  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strb,
  input  logic [2*SEG_COUNT-1:0]   segRegs,
  output logic [2*SEG_COUNT-1:0]   segLevels,
  output logic [1:0]               bp1Level,
  output logic [1:0]               bp2Level
);

  localparam int GROUP_W = 2 * REG_BITS;  // one even/odd register pair

  lvl_e actLvl;
  lvl_e oppLvl;
  logic regSel;
  logic [2*SEG_COUNT-1:0] segNext;
  logic [2*SEG_COUNT-1:0] segQ;
  logic [1:0] bp1Next, bp2Next, bp1Q, bp2Q;

  assign actLvl = strb.phase[0] ? LVL_LOW : LVL_HIGH;
  assign oppLvl = strb.phase[0] ? LVL_HIGH : LVL_LOW;
  // duplex: half-frame picks the register; two-level: the bank does
  assign regSel = strb.duplex ? strb.phase[1] : strb.bankSel;

  for (genvar n = 0; n < SEG_COUNT; n++) begin : gSeg
    localparam int GRP  = n / REG_BITS;
    localparam int BITI = n % REG_BITS;
    logic dataBit;
    assign dataBit = regSel ? segRegs[GRP*GROUP_W + REG_BITS + BITI]
                            : segRegs[GRP*GROUP_W + BITI];
    assign segNext[2*n +: 2] =
        strb.staticOn ? (dataBit ? LVL_HIGH : LVL_LOW) :
        !strb.live    ? LVL_LOW :
        dataBit       ? oppLvl : actLvl;
  end

  always_comb begin
    if (strb.staticOn) begin
      bp1Next = LVL_LOW;
      bp2Next = LVL_OFF;
    end else if (!strb.live) begin
      bp1Next = LVL_LOW;
      bp2Next = LVL_LOW;
    end else if (strb.duplex) begin
      bp1Next = strb.phase[1] ? LVL_MID : actLvl;
      bp2Next = strb.phase[1] ? actLvl  : LVL_MID;
    end else begin
      bp1Next = actLvl;
      bp2Next = LVL_OFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segQ <= '0;
      bp1Q <= LVL_LOW;
      bp2Q <= LVL_LOW;
    end else begin
      segQ <= segNext;
      bp1Q <= bp1Next;
      bp2Q <= bp2Next;
    end
  end

  assign segLevels = segQ;
  // a follower leaves the shared backplanes to the master
  assign bp1Level  = strb.cascade ? LVL_OFF : bp1Q;
  assign bp2Level  = strb.cascade ? LVL_OFF : bp2Q;

endmodule

// File: rtl/lcdWaveSeq.sv
module lcdWaveSeq
  import lcd_seq_pkg::*;
#(
  parameter int SEG_COUNT = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*SEG_COUNT-1:0] segRegs,
  input  logic                   duplexMode,
  input  logic                   bankSel,
  input  logic                   cascadeMode,
  input  logic                   expanderMode,
  input  logic                   oscTick,
  input  logic [1:0]             extBp1,
  input  logic [1:0]             extBp2,
  output logic [2*SEG_COUNT-1:0] segLevels,
  output logic [1:0]             bp1Level,
  output logic [1:0]             bp2Level
);

  seqStrobe_t strb;

  lcdSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .duplexMode(duplexMode), .bankSel(bankSel),
    .cascadeMode(cascadeMode), .expanderMode(expanderMode), .oscTick(oscTick),
    .extBp1(extBp1), .extBp2(extBp2), .strb(strb)
  );

  lcdSegPath #(.SEG_COUNT(SEG_COUNT)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .segRegs(segRegs),
    .segLevels(segLevels), .bp1Level(bp1Level), .bp2Level(bp2Level)
  );

endmodule

// File: rtl/lcdWaveSeq_chk.sv
module lcdWaveSeq_chk #(
  parameter int SEG_COUNT = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   duplexMode,
  input logic                   cascadeMode,
  input logic                   expanderMode,
  input logic [2*SEG_COUNT-1:0] segLevels,
  input logic [1:0]             bp1Level,
  input logic [1:0]             bp2Level
);

  function automatic int countCode(input logic [2*SEG_COUNT-1:0] v,
                                   input logic [1:0] code);
    int c = 0;
    for (int i = 0; i < SEG_COUNT; i++) if (v[2*i +: 2] == code) c++;
    return c;
  endfunction

  // R1: segments never released
  a_r1_seg_never_off: assert property (@(posedge clk) disable iff (!rstN)
    countCode(segLevels, 2'b11) == 0);

  // R5: one backplane at MID means the other is active
  a_r5_bp1_mid_pair: assert property (@(posedge clk) disable iff (!rstN)
    (bp1Level == 2'b01) |-> (bp2Level == 2'b10 || bp2Level == 2'b00));
  a_r5_bp2_mid_pair: assert property (@(posedge clk) disable iff (!rstN)
    (bp2Level == 2'b01) |-> (bp1Level == 2'b10 || bp1Level == 2'b00));

  // R2: two-level drive never produces a MID level
  a_r2_direct_no_mid: assert property (@(posedge clk) disable iff (!rstN)
    $past(!duplexMode) |->
      (countCode(segLevels, 2'b01) == 0 && bp1Level != 2'b01 && bp2Level != 2'b01));

  // R8: expander drive holds backplane 1 low and releases backplane 2
  a_r8_static_bp: assert property (@(posedge clk) disable iff (!rstN)
    ($past(expanderMode && !duplexMode && !cascadeMode) && !cascadeMode) |->
      (bp1Level == 2'b00 && bp2Level == 2'b11));

endmodule

bind lcdWaveSeq lcdWaveSeq_chk #(.SEG_COUNT(SEG_COUNT)) u_chk (
  .clk(clk), .rstN(rstN), .duplexMode(duplexMode), .cascadeMode(cascadeMode),
  .expanderMode(expanderMode), .segLevels(segLevels),
  .bp1Level(bp1Level), .bp2Level(bp2Level)
);

// File: tb/lcdWaveSeq_tb.sv
module lcdWaveSeq_tb;

  localparam logic [1:0] L = 2'b00, M = 2'b01, H = 2'b10, O = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] segRegs = '0;
  logic        duplexMode = 1'b0, bankSel = 1'b0, cascadeMode = 1'b0;
  logic        expanderMode = 1'b0, oscTick = 1'b0;
  logic [1:0]  extBp1 = M, extBp2 = M;
  logic [63:0] segLevels;
  logic [1:0]  bp1Level, bp2Level;

  int checks = 0;
  int fails = 0;
  logic       mLive = 1'b0;
  logic [1:0] mPhase = 2'd0;

  always #4 clk = ~clk;

  lcdWaveSeq u_dut (
    .clk(clk), .rstN(rstN), .segRegs(segRegs), .duplexMode(duplexMode),
    .bankSel(bankSel), .cascadeMode(cascadeMode), .expanderMode(expanderMode),
    .oscTick(oscTick), .extBp1(extBp1), .extBp2(extBp2),
    .segLevels(segLevels), .bp1Level(bp1Level), .bp2Level(bp2Level)
  );

  function automatic logic regBit(input int n, input logic sel);
    return segRegs[16*(n/8) + 8*int'(sel) + (n%8)];
  endfunction

  // expected outputs after the next edge, from the model state and inputs
  task automatic calcExp(output logic [63:0] s, output logic [1:0] b1, output logic [1:0] b2);
    logic [1:0] act, opp;
    logic sel;
    act = mPhase[0] ? L : H;
    opp = mPhase[0] ? H : L;
    sel = duplexMode ? mPhase[1] : bankSel;
    s = '0; b1 = L; b2 = L;
    if (!rstN) begin
      s = '0; b1 = L; b2 = L;
    end else if (expanderMode && !duplexMode && !cascadeMode) begin
      for (int n = 0; n < 32; n++) s[2*n +: 2] = regBit(n, bankSel) ? H : L;
      b1 = L; b2 = O;
    end else if (mLive) begin
      for (int n = 0; n < 32; n++) s[2*n +: 2] = regBit(n, sel) ? opp : act;
      if (duplexMode) begin
        b1 = mPhase[1] ? M : act;
        b2 = mPhase[1] ? act : M;
      end else begin
        b1 = act; b2 = O;
      end
    end
    if (cascadeMode) begin b1 = O; b2 = O; end
  endtask

  task automatic updModel();
    if (!rstN) begin
      mLive = 1'b0; mPhase = 2'd0;
    end else if (cascadeMode) begin
      if (extBp1 == H) begin mPhase = 2'd0; mLive = 1'b1; end
      else if (extBp1 == L) begin mPhase = 2'd1; mLive = 1'b1; end
      else if (duplexMode && extBp2 == H) begin mPhase = 2'd2; mLive = 1'b1; end
      else if (duplexMode && extBp2 == L) begin mPhase = 2'd3; mLive = 1'b1; end
    end else if (oscTick) begin
      if (!mLive) begin mLive = 1'b1; mPhase = 2'd0; end
      else if (duplexMode) mPhase = mPhase + 2'd1;
      else mPhase = {1'b0, ~mPhase[0]};
    end
  endtask

  function automatic string autoTag();
    if (!rstN) return "R9";
    if (expanderMode && !duplexMode && !cascadeMode) return "R8";
    if (cascadeMode) return "R7";
    if (!mLive) return "R9";
    if (duplexMode) return "R5/R6";
    return "R2/R3/R4";
  endfunction

  task automatic checkVal(input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: predict, clock, compare at the falling edge
  task automatic runCycle(input string tagIn);
    logic [63:0] eS;
    logic [1:0] e1, e2;
    string tag;
    tag = (tagIn == "") ? autoTag() : tagIn;
    calcExp(eS, e1, e2);
    @(posedge clk);
    updModel();
    @(negedge clk);
    checkVal(tag, {segLevels, bp1Level, bp2Level}, {eS, e1, e2});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    runCycle("R9");
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] expB1 [4];
    logic [1:0] expB2 [4];
    logic [1:0] expS0 [4];
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R9: blank with no tick yet
    repeat (3) runCycle("R9");
    checkVal("R9", {segLevels, bp1Level, bp2Level}, {64'd0, L, L});

    // R1 field positions / R3 polarity: register 7 bit 0 drives segment 24
    segRegs = '0;
    segRegs[63:56] = 8'h01;
    segRegs[55:48] = 8'h80;
    bankSel = 1'b1;
    oscTick = 1'b1; runCycle("");
    oscTick = 1'b0; runCycle("");
    checkVal("R1", {60'd0, segLevels[49:48], segLevels[63:62], bp1Level, bp2Level}, {60'd0, L, H, H, O});
    checkVal("R3", {66'd0, segLevels[1:0]}, {66'd0, H});

    // R4: bank swap without a tick
    bankSel = 1'b0; runCycle("R4");
    checkVal("R4", {64'd0, segLevels[49:48], segLevels[63:62]}, {64'd0, H, L});

    // R2: a tick toggles bp1
    oscTick = 1'b1; runCycle("R2");
    oscTick = 1'b0; runCycle("R2");
    checkVal("R2", {64'd0, bp1Level, bp2Level}, {64'd0, L, O});

    // R8: expander drive follows register bits directly
    expanderMode = 1'b1; runCycle("R8");
    checkVal("R8", {62'd0, segLevels[49:48], segLevels[63:62], bp1Level}, {62'd0, L, H, L});
    expanderMode = 1'b0;

    // R7: follower syncs to backplane 1 low, releases own backplanes
    cascadeMode = 1'b1; extBp1 = H; extBp2 = L;
    runCycle("R7"); runCycle("R7");
    extBp1 = L; runCycle("R7"); runCycle("R7");
    checkVal("R7", {62'd0, segLevels[63:62], bp1Level, bp2Level}, {62'd0, H, O, O});
    extBp1 = M; runCycle("R7");
    checkVal("R7", {62'd0, segLevels[63:62], bp1Level, bp2Level}, {62'd0, H, O, O});
    cascadeMode = 1'b0; extBp1 = M; extBp2 = M;

    // R5/R6: duplex four-phase walk, bank set to show it is ignored
    doReset();
    duplexMode = 1'b1; bankSel = 1'b1;
    segRegs = 64'h0000_0000_0000_0001;
    expB1 = '{H, L, M, M};
    expB2 = '{M, M, H, L};
    expS0 = '{L, H, H, L};
    for (int p = 0; p < 4; p++) begin
      oscTick = 1'b1; runCycle("R5");
      oscTick = 1'b0; runCycle("R6");
      checkVal("R5", {64'd0, bp1Level, bp2Level}, {64'd0, expB1[p], expB2[p]});
      checkVal("R6", {66'd0, segLevels[1:0]}, {66'd0, expS0[p]});
    end

    // R7: duplex follower decodes backplane 2
    cascadeMode = 1'b1; extBp1 = M; extBp2 = H;
    runCycle("R7"); runCycle("R7");
    checkVal("R7", {66'd0, segLevels[1:0]}, {66'd0, H});
    cascadeMode = 1'b0; extBp2 = M;

    // randomized stretches
    for (int blk = 0; blk < 60; blk++) begin
      if ($urandom_range(0, 9) == 0) doReset();
      duplexMode   = 1'($urandom);
      bankSel      = 1'($urandom);
      cascadeMode  = ($urandom_range(0, 3) == 0);
      expanderMode = ($urandom_range(0, 3) == 0);
      segRegs      = {$urandom, $urandom};
      for (int c = 0; c < 50; c++) begin
        oscTick = ($urandom_range(0, 3) == 0);
        extBp1  = 2'($urandom);
        extBp2  = 2'($urandom);
        if ($urandom_range(0, 15) == 0) bankSel = ~bankSel;
        if ($urandom_range(0, 15) == 0) segRegs = {$urandom, $urandom};
        runCycle("");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule